// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A word-addressed tick timer whose core is a 24-bit counter that only ever counts down. Software programs a reload value, chooses where counting pulses come from, and turns counting on. The pulses come either from every cycle of the core clock or from the rising edges of a slower reference clock. That reference signal is resynchronised and edge-detected inside the core clock domain, so each of its rising edges becomes exactly one core-clock count pulse.

Whenever the counter steps from one to zero, a sticky wrap flag in the control word is set. If interrupts are enabled, a one-cycle request pulse is also raised. On the pulse that follows, the counter is at zero, so it refills from the reload register instead of decrementing. A read-only calibration word reports three things, all fixed by parameters: whether a reference clock is fitted, whether the 10 ms count is inexact, and that 10 ms count. Access is through a simple single-cycle register port. Reads are combinational.

Top module: `tick_timer`

## Requirements
- R1: Byte address bits 3:2 pick the register: 0 = control, 1 = reload, 2 = current count, 3 = calibration. After reset, control, reload and current count all read 0 and the interrupt output is low.
- R2: Reload and current count keep only bits 23:0. Bits 31:24 read as 0, and writing 0xFFFFFFFF to reload reads back 0x00FFFFFF.
- R3: A write of any data to the current-count register sets the count to 0 on the next cycle and clears the wrap flag.
- R4: Control bit 0 enables counting. While it is 0, the count holds its value.
- R5: On each count pulse the count decrements by one. When the count is already 0, the pulse loads the reload value instead.
- R6: Control bit 2 selects the pulse source: 1 = every core clock cycle, 0 = one pulse for each rising edge of the reference input after a two-flop synchroniser. A reference level held high gives only one pulse.
- R7: Control bit 16 is the wrap flag. It is set on a step from 1 to 0 and cleared by a read of the control register. A read returns the flag's value from before the clear. Writing control bit 16 has no effect.
- R8: With control bit 1 set, every step from 1 to 0 gives exactly one interrupt pulse, one core clock wide. With control bit 1 clear, no pulse is given.
- R9: The calibration word reads bit 31 = no-reference parameter, bit 30 = inexact parameter, bits 23:0 = 10 ms count parameter, and all other bits 0. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench keeps the full 24-bit counter width, so loading 0xFFFFFFFF and counting two pulses shows that the top byte is masked and that the count decrements correctly from its maximum. Small reload values (3 and 5) bring the reload-at-zero step, the wrap flag and the interrupt pulse within a few dozen cycles. The calibration parameters are set to no-reference 0, inexact 1 and a count of 500. The expected word, 0x400001F4, therefore uses both flag bits with different values and a nonzero count field.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_RELOAD  = 2'd1,
        REG_CURRENT = 2'd2,
        REG_CALIB   = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;

    localparam int BUS_W = 32;

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], ref_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // last synchroniser stage high, history stage low: one rising edge
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap_d;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_d = 1'b0;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == '0) begin
                cnt_d = reload_i;
            end else begin
                cnt_d  = cnt_q - ONE;
                wrap_d = (cnt_q == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign wrap_o  = wrap_d;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int               CNT_W       = 24,
    parameter int               SYNC_STAGES = 2,
    parameter logic             NO_REF      = 1'b0,
    parameter logic             INEXACT     = 1'b0,
    parameter logic [CNT_W-1:0] TEN_MS      = CNT_W'(100000)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_clk_i,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    localparam int              PAD_W    = BUS_W - 2 - CNT_W;
    localparam logic [BUS_W-1:0] CAL_WORD = {NO_REF, INEXACT, {PAD_W{1'b0}}, TEN_MS};

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             src_core;
        logic             flag;
        logic [CNT_W-1:0] reload;
        logic             irq;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e         reg_sel;
    logic             rd_ctrl, wr_ctrl, wr_reload, wr_current;
    logic             ref_rise, tick, wrap;
    logic [CNT_W-1:0] count;
    logic             unused_bits;

    assign reg_sel     = reg_sel_e'(bus_addr[3:2]);
    assign rd_ctrl     = bus_sel & ~bus_wr & (reg_sel == REG_CTRL);
    assign wr_ctrl     = bus_sel &  bus_wr & (reg_sel == REG_CTRL);
    assign wr_reload   = bus_sel &  bus_wr & (reg_sel == REG_RELOAD);
    assign wr_current  = bus_sel &  bus_wr & (reg_sel == REG_CURRENT);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    tick_ref_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_clk_i),
        .rise_o (ref_rise)
    );

    assign tick = st_q.en & (st_q.src_core | ref_rise);

    tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .clear_i  (wr_current),
        .reload_i (st_q.reload),
        .count_o  (count),
        .wrap_o   (wrap)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.en       = bus_wdata[CTRL_EN_BIT];
            st_d.ie       = bus_wdata[CTRL_IE_BIT];
            st_d.src_core = bus_wdata[CTRL_SRC_BIT];
        end
        if (wr_reload) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        if (rd_ctrl || wr_current) begin
            st_d.flag = 1'b0;
        end
        if (wrap) begin
            st_d.flag = 1'b1;
        end
        st_d.irq = wrap & st_q.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_sel)
                REG_CTRL: begin
                    bus_rdata[CTRL_EN_BIT]   = st_q.en;
                    bus_rdata[CTRL_IE_BIT]   = st_q.ie;
                    bus_rdata[CTRL_SRC_BIT]  = st_q.src_core;
                    bus_rdata[CTRL_FLAG_BIT] = st_q.flag;
                end
                REG_RELOAD:  bus_rdata = BUS_W'(st_q.reload);
                REG_CURRENT: bus_rdata = BUS_W'(count);
                REG_CALIB:   bus_rdata = CAL_WORD;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
    parameter int               CNT_W   = 24,
    parameter logic             NO_REF  = 1'b0,
    parameter logic             INEXACT = 1'b0,
    parameter logic [CNT_W-1:0] TEN_MS  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt,
    input logic             en,
    input logic             src_core,
    input logic             ie,
    input logic             flag
);
    localparam logic [31:0] CAL = {NO_REF, INEXACT, {(30-CNT_W){1'b0}}, TEN_MS};

    logic wr_cur;
    assign wr_cur = bus_sel && bus_wr && (bus_addr[3:2] == 2'd2);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr[3:2] == 2'd1 || bus_addr[3:2] == 2'd2))
        |-> (bus_rdata[31:24] == 8'h00));

    assert_clear_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur |=> (cnt == '0));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_cur) |=> $stable(cnt));

    assert_core_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && src_core && !wr_cur && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_flag_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ie));

    assert_calib_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[3:2] == 2'd3) |-> (bus_rdata == CAL));

endmodule

bind tick_timer tick_timer_checker #(
    .CNT_W   (CNT_W),
    .NO_REF  (NO_REF),
    .INEXACT (INEXACT),
    .TEN_MS  (TEN_MS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .cnt       (count),
    .en        (st_q.en),
    .src_core  (st_q.src_core),
    .ie        (st_q.ie),
    .flag      (st_q.flag)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

    localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk_i = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    int irq_pulses = 0;
    bit irq_prev = 1'b0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    tick_timer #(
        .CNT_W   (24),
        .NO_REF  (1'b0),
        .INEXACT (1'b1),
        .TEN_MS  (24'h0001F4)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_clk_i (ref_clk_i),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // irq pulse counter and width monitor
    always @(posedge clk) begin
        if (irq_o === 1'b1) irq_pulses++;
        if (irq_o === 1'b1 && irq_prev) begin
            checks++;
            errors++;
            $display("FAIL R8: actual=wide pulse expected=single cycle");
        end
        irq_prev = (irq_o === 1'b1);
    end

    // scoreboard monitor: compare read data a little after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_sel && !bus_wr && exp_q.size() > 0) begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // exactly n core-clock pulses (n >= 2)
    task automatic run_core(int n, bit ie);
        bus_write(A_CTRL, ie ? 32'h7 : 32'h5);
        idle(n - 2);
        bus_write(A_CTRL, ie ? 32'h6 : 32'h4);
    endtask

    task automatic ref_edges(int n);
        repeat (n) begin
            ref_clk_i = 1'b1; idle(6);
            ref_clk_i = 1'b0; idle(6);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        bus_read(A_CTRL, 32'h0, "R1 ctrl after reset");
        bus_read(A_RLD,  32'h0, "R1 reload after reset");
        bus_read(A_CUR,  32'h0, "R1 current after reset");
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        // calibration word, write ignored
        bus_read(A_CAL, 32'h400001F4, "R9 calibration");
        bus_write(A_CAL, 32'h0);
        bus_read(A_CAL, 32'h400001F4, "R9 calibration after write");

        // core clock: load at zero then decrement
        bus_write(A_RLD, 32'h3);
        bus_read(A_RLD, 32'h3, "R1 reload readback");
        run_core(3, 1'b0);
        bus_read(A_CUR, 32'h1, "R5 load then decrement");
        bus_read(A_CTRL, 32'h4, "R7 flag clear before wrap");
        run_core(2, 1'b0);
        bus_read(A_CUR, 32'h3, "R5 reload after wrap");
        bus_read(A_CTRL, 32'h0001_0004, "R7 flag set on wrap");
        bus_read(A_CTRL, 32'h4, "R7 flag cleared by read");
        idle(10);
        bus_read(A_CUR, 32'h3, "R4 hold while disabled");
        check("R8 no irq with ie clear", irq_pulses, 0);

        // interrupt path
        bus_write(A_CUR, 32'h123);
        bus_read(A_CUR, 32'h0, "R3 write clears current");
        run_core(4, 1'b1);
        idle(2);
        check("R8 one irq pulse", irq_pulses, 1);
        bus_read(A_CUR, 32'h0, "R5 stop at zero");
        bus_read(A_CTRL, 32'h0001_0006, "R7 flag with ie");
        bus_read(A_CTRL, 32'h6, "R7 flag clear after read");
        run_core(5, 1'b1);
        bus_write(A_CUR, 32'hFFFF_FFFF);
        bus_read(A_CTRL, 32'h6, "R3 write clears flag");
        bus_read(A_CUR, 32'h0, "R3 any data clears");
        check("R8 second irq pulse", irq_pulses, 2);

        // flag bit not writable
        bus_write(A_CTRL, 32'h0001_0000);
        bus_read(A_CTRL, 32'h0, "R7 flag not writable");

        // reference source
        bus_write(A_RLD, 32'h5);
        bus_write(A_CTRL, 32'h1);
        ref_edges(3);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CUR, 32'h3, "R6 one pulse per reference edge");
        bus_write(A_CTRL, 32'h1);
        ref_clk_i = 1'b1; idle(20);
        ref_clk_i = 1'b0; idle(6);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CUR, 32'h2, "R6 held level gives one pulse");
        ref_edges(2);
        bus_read(A_CUR, 32'h2, "R4 reference ignored when disabled");

        // full-width reload
        bus_write(A_RLD, 32'hFFFF_FFFF);
        bus_read(A_RLD, 32'h00FF_FFFF, "R2 reload masked");
        bus_write(A_CUR, 32'h0);
        run_core(2, 1'b0);
        bus_read(A_CUR, 32'h00FF_FFFE, "R2 count from maximum");

        idle(4);
        done = 1'b1;
        finish_run();
    end

endmodule